// File: doc/BRIEF.md
# Registered/Combinatorial Output Cell Array

This block is the output stage of a small programmable logic array. Each cell takes one sum-of-products term from the array. A per-cell select decides whether that term goes straight to the pad or passes through a D flip-flop first. A per-cell polarity bit then keeps the chosen value or inverts it. The pad is modelled as a data bit plus a drive enable. A cell drives only when the shared active-low enable pin is low and its own enable product term is high.

For testing, a shared preload control makes every register take the value present on its pad pin at the next clock edge. This skips the normal capture, so any state can be forced, including states that the logic could never reach. A single asynchronous active-low reset stands in for power-up and clears every register. The array, the clock product terms and the electrical pad behaviour are outside this block. `NUM_CELLS` sets how many identical cells sit side by side.

Top module: `oc_macrocell`

## Requirements
- R1: While `oe_glob_ni` is 0, `pad_oe_o[i]` equals `oe_term_i[i]` for every cell.
- R2: While `oe_glob_ni` is 1, every bit of `pad_oe_o` is 0, whatever `oe_term_i` holds.
- R3: A cell whose `oe_term_i` bit is 0 has its `pad_oe_o` bit at 0, and the other cells are not affected.
- R4: `pol_cfg_i[i]`=1 makes `pad_o[i]` equal to the selected source bit (active-high). `pol_cfg_i[i]`=0 makes it the inverse (active-low).
- R5: With `reg_sel_i[i]`=1 the source is the cell's register. On each rising clock edge without preload, the register takes `sop_i[i]`, and `pad_o` shows the new value right after that edge.
- R6: With `reg_sel_i[i]`=0 the source is `sop_i[i]` itself, and `pad_o[i]` follows it without waiting for a clock edge.
- R7: `rst_ni`=0 clears every register at once, without a clock. A registered cell with `pol_cfg_i`=0 then drives `pad_o`=1.
- R8: When `preload_i`=1 at a rising edge, each register loads `pad_i[i]` in place of `sop_i[i]`. Preload wins over normal capture.
- R9: After a preloaded state, including an unreachable one, the first edge with `preload_i`=0 loads `sop_i` again.
- R10: `preload_i` has no effect on `pad_oe_o` or on combinatorial cells' `pad_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| sop_i | input | NUM_CELLS | Sum-of-products term per cell |
| oe_term_i | input | NUM_CELLS | Per-cell enable product term, active-high |
| oe_glob_ni | input | 1 | Shared output enable pin, active-low |
| pol_cfg_i | input | NUM_CELLS | Polarity bit: 1 active-high, 0 active-low |
| reg_sel_i | input | NUM_CELLS | Source select: 1 register, 0 combinatorial |
| preload_i | input | 1 | Register preload control |
| pad_i | input | NUM_CELLS | Value seen on the pad pins |
| pad_o | output | NUM_CELLS | Pad data |
| pad_oe_o | output | NUM_CELLS | Pad drive enable |

## Verification
A register left in the wrong state appears on `pad_o` of a registered cell right after the edge that set it, inverted if the polarity bit is 0. It can therefore be seen within one clock. A broken preload path shows up as a pad value that matches `sop_i` where the preloaded pin value was expected. A missing recovery shows up as the forced value persisting past the next capture edge. Enable faults are purely combinatorial and can be seen on `pad_oe_o` in the same cycle as the stimulus.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic {
    SRC_COMB = 1'b0,
    SRC_REG  = 1'b1
  } src_e;
endpackage

// File: rtl/oc_out_enable.sv
module oc_out_enable (
  input  logic glob_ni,
  input  logic term_i,
  output logic oe_o
);
  assign oe_o = ~glob_ni & term_i;
endmodule

// File: rtl/oc_polarity.sv
module oc_polarity (
  input  logic val_i,
  input  logic pol_i,
  output logic val_o
);
  // pol_i=1 passes the value, pol_i=0 inverts it
  assign val_o = val_i ^ ~pol_i;
endmodule

// File: rtl/oc_cell.sv
module oc_cell
  import oc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sop_i,
  input  logic pad_i,
  input  logic preload_i,
  input  src_e src_i,
  input  logic pol_i,
  output logic dat_o
);
  logic q;
  logic src_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q <= 1'b0;
    else if (preload_i) q <= pad_i;
    else                q <= sop_i;
  end

  always_comb begin
    unique case (src_i)
      SRC_REG:  src_val = q;
      default:  src_val = sop_i;
    endcase
  end

  oc_polarity u_pol (
    .val_i (src_val),
    .pol_i (pol_i),
    .val_o (dat_o)
  );
endmodule

// File: rtl/oc_macrocell.sv
module oc_macrocell
  import oc_pkg::*;
#(
  parameter int NUM_CELLS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CELLS-1:0] sop_i,
  input  logic [NUM_CELLS-1:0] oe_term_i,
  input  logic                 oe_glob_ni,
  input  logic [NUM_CELLS-1:0] pol_cfg_i,
  input  logic [NUM_CELLS-1:0] reg_sel_i,
  input  logic                 preload_i,
  input  logic [NUM_CELLS-1:0] pad_i,
  output logic [NUM_CELLS-1:0] pad_o,
  output logic [NUM_CELLS-1:0] pad_oe_o
);
  for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
    oc_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sop_i     (sop_i[g]),
      .pad_i     (pad_i[g]),
      .preload_i (preload_i),
      .src_i     (src_e'(reg_sel_i[g])),
      .pol_i     (pol_cfg_i[g]),
      .dat_o     (pad_o[g])
    );

    oc_out_enable u_oe (
      .glob_ni (oe_glob_ni),
      .term_i  (oe_term_i[g]),
      .oe_o    (pad_oe_o[g])
    );
  end
endmodule

// File: rtl/oc_macrocell_chk.sv
module oc_macrocell_chk #(
  parameter int NUM_CELLS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CELLS-1:0] sop_i,
  input logic [NUM_CELLS-1:0] oe_term_i,
  input logic                 oe_glob_ni,
  input logic [NUM_CELLS-1:0] pol_cfg_i,
  input logic [NUM_CELLS-1:0] reg_sel_i,
  input logic                 preload_i,
  input logic [NUM_CELLS-1:0] pad_i,
  input logic [NUM_CELLS-1:0] pad_o,
  input logic [NUM_CELLS-1:0] pad_oe_o
);
  AST_ENABLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_glob_ni |-> pad_oe_o == oe_term_i); // R1
  AST_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_glob_ni |-> pad_oe_o == '0); // R2
  AST_LOCAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~oe_term_i) == '0); // R3
  AST_COMB_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o ^ ~pol_cfg_i ^ sop_i) & ~reg_sel_i) == '0); // R6
  AST_REG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(preload_i)) |->
      (((pad_o ^ ~pol_cfg_i) ^ $past(sop_i)) & reg_sel_i) == '0); // R5
  AST_PRELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(preload_i)) |->
      (((pad_o ^ ~pol_cfg_i) ^ $past(pad_i)) & reg_sel_i) == '0); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> ((pad_o ^ ~pol_cfg_i) & reg_sel_i) == '0); // R7
endmodule

bind oc_macrocell oc_macrocell_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sop_i      (sop_i),
  .oe_term_i  (oe_term_i),
  .oe_glob_ni (oe_glob_ni),
  .pol_cfg_i  (pol_cfg_i),
  .reg_sel_i  (reg_sel_i),
  .preload_i  (preload_i),
  .pad_i      (pad_i),
  .pad_o      (pad_o),
  .pad_oe_o   (pad_oe_o)
);

// File: tb/sim_oc_macrocell.sv
module sim_oc_macrocell;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] sop_i = '0, oe_term_i = '0, pol_cfg_i = '0, reg_sel_i = '0, pad_i = '0;
  logic         oe_glob_ni = 1'b1, preload_i = 1'b0;
  logic [W-1:0] pad_o, pad_oe_o;

  int total = 0;
  int bad = 0;
  logic [W-1:0] mq = '0;

  typedef struct {
    logic [W-1:0] pd;
    logic [W-1:0] oe;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk_i = ~clk_i;

  oc_macrocell #(.NUM_CELLS(W)) u0 (
    .clk_i, .rst_ni, .sop_i, .oe_term_i, .oe_glob_ni, .pol_cfg_i,
    .reg_sel_i, .preload_i, .pad_i, .pad_o, .pad_oe_o
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_pad();
    logic [W-1:0] s;
    s = (reg_sel_i & mq) | (~reg_sel_i & sop_i);
    return s ^ ~pol_cfg_i;
  endfunction

  // driver: apply at negedge, model the register update, queue expectation
  task automatic step(logic g, logic [W-1:0] t, logic [W-1:0] p, logic [W-1:0] r,
                      logic [W-1:0] s, logic pre, logic [W-1:0] pin, string tag);
    exp_t e;
    @(negedge clk_i);
    oe_glob_ni = g; oe_term_i = t; pol_cfg_i = p; reg_sel_i = r;
    sop_i = s; preload_i = pre; pad_i = pin;
    mq = pre ? pin : s;
    e.pd = exp_pad();
    e.oe = {W{~g}} & t;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " pad"}, pad_o, e.pd);
        check({e.tag, " oe"}, pad_oe_o, e.oe);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R7: reset state, registered active-low cells read high
    reg_sel_i = '1; pol_cfg_i = '0; oe_glob_ni = 1'b0; oe_term_i = '1; sop_i = 4'b0101;
    #13;
    check("R7 reset pad", pad_o, 4'b1111);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R2 R3: enable combinations
    step(1'b0, 4'b1010, '0, '0, 4'b0000, 1'b0, '0, "R1 R3 glob0 term1010");
    step(1'b0, 4'b0101, '0, '0, 4'b0000, 1'b0, '0, "R1 R3 glob0 term0101");
    step(1'b1, 4'b1111, '0, '0, 4'b0000, 1'b0, '0, "R2 glob1 term1111");
    step(1'b1, 4'b0000, '0, '0, 4'b0000, 1'b0, '0, "R2 glob1 term0000");
    step(1'b0, 4'b0000, '0, '0, 4'b0000, 1'b0, '0, "R3 glob0 term0000");

    // R4: polarity both ways, combinatorial
    step(1'b0, '1, 4'b1111, '0, 4'b0110, 1'b0, '0, "R4 active-high");
    step(1'b0, '1, 4'b0000, '0, 4'b0110, 1'b0, '0, "R4 active-low");
    step(1'b0, '1, 4'b1100, '0, 4'b0110, 1'b0, '0, "R4 mixed");

    // R5: registered capture sequence
    step(1'b0, '1, 4'b1111, '1, 4'b0011, 1'b0, '0, "R5 cap 0011");
    step(1'b0, '1, 4'b1111, '1, 4'b1001, 1'b0, '0, "R5 cap 1001");
    step(1'b0, '1, 4'b0101, '1, 4'b1100, 1'b0, '0, "R5 R4 cap 1100");

    // R6: combinatorial follows mid-cycle without an edge
    step(1'b0, '1, 4'b1111, 4'b0011, 4'b0110, 1'b0, '0, "R6 mixed sel");
    @(negedge clk_i);
    #1;
    sop_i = 4'b1001;
    #1;
    check("R6 comb mid-cycle", pad_o & 4'b1100, 4'b1000);
    @(negedge clk_i);
    mq = sop_i;

    // R8: preload an illegal state with drivers off
    step(1'b1, '1, 4'b1111, '1, 4'b0000, 1'b1, 4'b1011, "R8 preload 1011");
    step(1'b1, '1, 4'b0000, '1, 4'b1111, 1'b1, 4'b0110, "R8 preload 0110 pol0");
    // R9: recovery on the next normal edge
    step(1'b0, '1, 4'b1111, '1, 4'b0001, 1'b0, 4'b1111, "R9 recover 0001");
    // R10: preload leaves comb cells and enables alone
    step(1'b0, 4'b0110, 4'b1111, '0, 4'b1010, 1'b1, 4'b0101, "R10 comb under preload");
    step(1'b0, 4'b1001, 4'b1111, 4'b1100, 4'b0011, 1'b1, 4'b1010, "R10 R8 mixed preload");

    // R7: asynchronous reset mid-cycle
    step(1'b0, '1, 4'b0000, '1, 4'b0000, 1'b0, '0, "R5 load zeros");
    step(1'b0, '1, 4'b0000, '1, 4'b1111, 1'b0, '0, "R5 load ones");
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0;
    #1;
    check("R7 async clear", pad_o, 4'b1111);
    mq = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, '1, 4'b1111, '1, 4'b1010, 1'b0, '0, "R5 after reset");

    repeat (3) @(posedge clk_i);
    #3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule